// File: doc/BRIEF.md
# Management PHY Register Model

This block is a synthesizable replacement for the management register file of an Ethernet transceiver. Software, or a controller, issues one 32-bit command word. The word encodes a read or a write, a 9-bit register number and 16 bits of write data. The block executes the command in a single cycle. On the next clock edge it leaves the outcome in a command register and raises a one-cycle done pulse.

The block holds five registers: control, status, advertisement, interrupt source and interrupt mask. Reads of the identity, link-partner and expansion registers return fixed values. Each writable register masks or forces bits in the value written to it. The block follows a link input: link up and link down set or clear status bits and latch events in the interrupt source. A control write can reset the whole file, or it can mark auto-negotiation complete at once. A read of the interrupt source clears it. No serial management timing is modelled.

Top module: `mgmt_phy_model`

## Requirements
- R1: After reset (`rst_n` low at a clock edge), control reads 0x3000, advertisement reads 0x01E1 and mask reads 0. Status reads 0x7809 and the interrupt source reads 0, each with the link state applied on the first edge after reset. With the link up, status reads 0x782D and the interrupt source reads 0x00C0. `done` is 0 and the command register is 0.
- R2: When `link_up` rises, status bits 5 and 2 (0x0024) are set and interrupt-source bits 7 and 6 are set. When `link_up` falls, bits 0x0024 of status are cleared and interrupt-source bit 4 is set. A change takes effect on the edge that samples the new level.
- R3: A write to register 0 with data bit 15 set returns every register to its R1 value. The link state is applied again on the next edge.
- R4: A write to register 0 with data bit 15 clear stores data AND 0x7980 in control. If data bit 12 is 1, status bit 5 (0x0020) is also set in the same cycle.
- R5: A write to register 4 stores (data AND 0x2D7F) OR 0x0080.
- R6: Registers 2, 3, 5 and 6 read 0x0007, 0xC0D1, 0x0F71 and 0x0001. Writes to them have no effect.
- R7: A read of register 29 returns the interrupt source and clears it in the same access. A link event in that cycle sets its bits after the clear.
- R8: Register 30 is an 8-bit mask. A write stores data AND 0x00FF.
- R9: Command word layout: bit 28 = 1 selects a write and 0 selects a read; bits 26:18 hold the register number; bits 15:0 hold the write data. After a write, `cmd_reg` holds the full command word. After a read, it holds the read value zero-extended to 32 bits.
- R10: Register numbers above 31, and unlisted numbers up to 31, read as 0. Writes to them change no register.
- R11: Every command, read or write, is followed on the next clock edge by `done` high for exactly one cycle. There is no pulse without a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one command per high cycle |
| cmd_word | input | 32 | Command word (R9 layout) |
| link_up | input | 1 | Current link level |
| cmd_reg | output | 32 | Command register / read result |
| done | output | 1 | One-cycle completion pulse |

## Verification
A full sweep of reads over register numbers 0 to 40, plus a few large numbers, tells the constant registers apart from the stored ones and from the zero-reading holes. Several data patterns go to each writable register: all zeros, all ones, alternating bits, and values with only the control bits that matter set. These patterns separate the per-register masks and forced bits. A write sweep over every unlisted number shows that no stored register moves. Link toggles with and without reads of the interrupt source in between show the set-only latching and the clear-on-read behaviour. Soft resets are issued with the link both up and down.

// File: rtl/mgmt_phy_pkg.sv
// Shared constants and types for the management PHY register model.
// Assumes a 32-bit command word and 16-bit registers.
package mgmt_phy_pkg;
    localparam int CMD_W     = 32;
    localparam int DATA_W    = 16;
    localparam int REGN_W    = 9;
    localparam int WR_BIT    = 28;
    localparam int REGN_LSB  = 18;
    localparam int ISRC_W    = 8;
    localparam int LAST_REG  = 31;

    localparam logic [DATA_W-1:0] CTRL_RST   = 16'h3000;
    localparam logic [DATA_W-1:0] STAT_RST   = 16'h7809;
    localparam logic [DATA_W-1:0] ADV_RST    = 16'h01E1;
    localparam logic [DATA_W-1:0] CTRL_MASK  = 16'h7980;
    localparam logic [DATA_W-1:0] ADV_MASK   = 16'h2D7F;
    localparam logic [DATA_W-1:0] ADV_FORCE  = 16'h0080;
    localparam logic [DATA_W-1:0] LINK_BITS  = 16'h0024;
    localparam logic [DATA_W-1:0] ANEG_DONE  = 16'h0020;
    localparam logic [ISRC_W-1:0] EV_UP      = 8'hC0;
    localparam logic [ISRC_W-1:0] EV_DOWN    = 8'h10;

    typedef struct packed {
        logic              is_write;
        logic              in_range;
        logic [REGN_W-1:0] regn;
        logic [DATA_W-1:0] wdata;
    } mgmt_cmd_t;
endpackage

// File: rtl/mgmt_cmd_decode.sv
// Splits a command word into direction, register number and data.
// Purely combinational; assumes the layout fixed in mgmt_phy_pkg.
module mgmt_cmd_decode
    import mgmt_phy_pkg::*;
(
    input  logic [CMD_W-1:0] word,
    output mgmt_cmd_t        cmd
);
    // field extraction and range check
    always_comb begin
        cmd.is_write = word[WR_BIT];
        cmd.regn     = word[REGN_LSB +: REGN_W];
        cmd.wdata    = word[DATA_W-1:0];
        cmd.in_range = (word[REGN_LSB +: REGN_W] <= REGN_W'(LAST_REG));
    end
endmodule

// File: rtl/mgmt_link_tracker.sv
// Detects changes of the link input and requests a link evaluation
// after any reset. Assumes link_up is already synchronous to clk.
module mgmt_link_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic link_up,
    output logic link_evt
);
    logic link_q;
    logic eval_pend;

    // remember last sampled level and pending post-reset evaluation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q    <= link_up;
            eval_pend <= 1'b1;
        end else begin
            link_q    <= link_up;
            eval_pend <= soft_rst;
        end
    end

    // evaluation needed after reset or on any level change
    assign link_evt = eval_pend || (link_up != link_q);
endmodule

// File: rtl/mgmt_phy_regfile.sv
// Register file of the PHY model: masked writes, constant registers,
// clear-on-read interrupt source and link-driven status updates.
// Assumes at most one command per cycle; rdata reflects pre-access state.
module mgmt_phy_regfile
    import mgmt_phy_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  mgmt_cmd_t         cmd,
    input  logic              link_evt,
    input  logic              link_up,
    output logic              soft_rst,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] ctrl_q, stat_q, adv_q;
    logic [ISRC_W-1:0] mask_q, isrc_q;
    logic [DATA_W-1:0] ctrl_n, stat_n, adv_n;
    logic [ISRC_W-1:0] mask_n, isrc_n;
    logic wr_en, rd_en;

    assign wr_en    = cmd_valid && cmd.is_write && cmd.in_range;
    assign rd_en    = cmd_valid && !cmd.is_write && cmd.in_range;
    assign soft_rst = wr_en && (cmd.regn == '0) && cmd.wdata[15];

    // next-state: command effects first, link event layered on top
    always_comb begin
        ctrl_n = ctrl_q;
        stat_n = stat_q;
        adv_n  = adv_q;
        mask_n = mask_q;
        isrc_n = isrc_q;
        if (soft_rst) begin
            ctrl_n = CTRL_RST;
            stat_n = STAT_RST;
            adv_n  = ADV_RST;
            mask_n = '0;
            isrc_n = '0;
        end else begin
            if (wr_en) begin
                case (cmd.regn)
                    9'd0: begin
                        ctrl_n = cmd.wdata & CTRL_MASK;
                        if (cmd.wdata[12]) stat_n = stat_n | ANEG_DONE;
                    end
                    9'd4:  adv_n  = (cmd.wdata & ADV_MASK) | ADV_FORCE;
                    9'd30: mask_n = cmd.wdata[ISRC_W-1:0];
                    default: ;
                endcase
            end
            if (rd_en && cmd.regn == 9'd29) isrc_n = '0;
            if (link_evt) begin
                if (link_up) begin
                    stat_n = stat_n | LINK_BITS;
                    isrc_n = isrc_n | EV_UP;
                end else begin
                    stat_n = stat_n & ~LINK_BITS;
                    isrc_n = isrc_n | EV_DOWN;
                end
            end
        end
    end

    // state registers with reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            stat_q <= STAT_RST;
            adv_q  <= ADV_RST;
            mask_q <= '0;
            isrc_q <= '0;
        end else begin
            ctrl_q <= ctrl_n;
            stat_q <= stat_n;
            adv_q  <= adv_n;
            mask_q <= mask_n;
            isrc_q <= isrc_n;
        end
    end

    // read multiplexer over current state and constants
    always_comb begin
        rdata = '0;
        if (cmd.in_range) begin
            case (cmd.regn)
                9'd0:  rdata = ctrl_q;
                9'd1:  rdata = stat_q;
                9'd2:  rdata = 16'h0007;
                9'd3:  rdata = 16'hC0D1;
                9'd4:  rdata = adv_q;
                9'd5:  rdata = 16'h0F71;
                9'd6:  rdata = 16'h0001;
                9'd29: rdata = DATA_W'(isrc_q);
                9'd30: rdata = DATA_W'(mask_q);
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mgmt_phy_model.sv
// Top of the management PHY register model. Accepts one command per
// cycle on cmd_valid; result and done pulse appear on the next edge.
// Assumes synchronous active-low reset and a synchronous link input.
module mgmt_phy_model
    import mgmt_phy_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             link_up,
    output logic [CMD_W-1:0] cmd_reg,
    output logic             done
);
    mgmt_cmd_t         cmd;
    logic              soft_rst;
    logic              link_evt;
    logic [DATA_W-1:0] rdata;

    mgmt_cmd_decode u_dec (.word(cmd_word), .cmd(cmd));

    mgmt_link_tracker u_link (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .link_up(link_up), .link_evt(link_evt)
    );

    mgmt_phy_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .link_evt(link_evt), .link_up(link_up),
        .soft_rst(soft_rst), .rdata(rdata)
    );

    // command register and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_reg <= '0;
            done    <= 1'b0;
        end else begin
            done <= cmd_valid;
            if (cmd_valid)
                cmd_reg <= cmd.is_write ? cmd_word : CMD_W'(rdata);
        end
    end
endmodule

// File: rtl/mgmt_phy_checker.sv
// Port-level properties of mgmt_phy_model, bound onto every instance.
module mgmt_phy_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [31:0] cmd_word,
    input logic [31:0] cmd_reg,
    input logic        done
);
    // R11: a command yields a done pulse on the next edge
    p_done_after_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> done);
    // R11: no pulse without a command
    p_no_spurious_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !done);
    // R9: a write leaves the full command word behind
    p_write_echo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[28]) |=> (cmd_reg == $past(cmd_word)));
    // R6: identity register 3 constant
    p_id_const_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_word[28] && cmd_word[26:18] == 9'd3)
        |=> (cmd_reg == 32'h0000C0D1));
    // R10: out-of-range read returns zero
    p_high_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_word[28] && cmd_word[26:18] > 9'd31)
        |=> (cmd_reg == 32'h0));
    // R9: reads never leave bits above 15 set
    p_read_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_word[28]) |=> (cmd_reg[31:16] == 16'h0));
endmodule

bind mgmt_phy_model mgmt_phy_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_reg(cmd_reg), .done(done)
);

// File: tb/tb_mgmt_phy_model.sv
module tb_mgmt_phy_model;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        link_up = 1'b1;
    logic [31:0] cmd_reg;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of register state
    logic [15:0] m_ctrl, m_stat, m_adv;
    logic [7:0]  m_mask, m_isrc;

    always #4 clk = ~clk;

    mgmt_phy_model dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_word(cmd_word), .link_up(link_up), .cmd_reg(cmd_reg), .done(done));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void m_link();
        if (link_up) begin m_stat |= 16'h0024; m_isrc |= 8'hC0; end
        else begin m_stat &= ~16'h0024; m_isrc |= 8'h10; end
    endfunction

    function automatic void m_reset();
        m_ctrl = 16'h3000; m_stat = 16'h7809; m_adv = 16'h01E1;
        m_mask = 0; m_isrc = 0;
        m_link();
    endfunction

    function automatic logic [15:0] m_read(input int r);
        logic [15:0] v;
        case (r)
            0: v = m_ctrl;  1: v = m_stat;  2: v = 16'h0007; 3: v = 16'hC0D1;
            4: v = m_adv;   5: v = 16'h0F71; 6: v = 16'h0001;
            29: begin v = {8'h0, m_isrc}; m_isrc = 0; end
            30: v = {8'h0, m_mask};
            default: v = 0;
        endcase
        return v;
    endfunction

    function automatic void m_write(input int r, input logic [15:0] d);
        if (r == 0) begin
            if (d[15]) m_reset();
            else begin
                m_ctrl = d & 16'h7980;
                if (d[12]) m_stat |= 16'h0020;
            end
        end else if (r == 4) m_adv = (d & 16'h2D7F) | 16'h0080;
        else if (r == 30) m_mask = d[7:0];
    endfunction

    // one command: drive at negedge, check result one cycle later
    task automatic do_cmd(input string req, input bit wr, input int r, input logic [15:0] d);
        logic [31:0] w;
        logic [31:0] exp;
        w = {3'b000, wr, 1'b0, 9'(r), 2'b10, d};
        @(negedge clk);
        cmd_word = w; cmd_valid = 1'b1;
        if (wr) begin m_write(r, d); exp = w; end
        else exp = {16'h0, m_read(r)};
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({req, " R11 done"}, {31'h0, done}, 32'h1);
        chk(req, cmd_reg, exp);
        @(negedge clk);
        chk({req, " R11 pulse width"}, {31'h0, done}, 32'h0);
    endtask

    task automatic set_link(input bit v);
        @(negedge clk);
        link_up = v;
        m_link();
        @(negedge clk);
    endtask

    initial begin : watchdog
        #1600000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_reset();
        @(negedge clk);
        chk("R1 done at reset", {31'h0, done}, 32'h0);
        chk("R1 cmd_reg at reset", cmd_reg, 32'h0);
        do_cmd("R1 control", 0, 0, 0);
        do_cmd("R1 status", 0, 1, 0);
        chk("R1 status value", {16'h0, m_stat}, 32'h782D);
        do_cmd("R1 advert", 0, 4, 0);
        do_cmd("R1 mask", 0, 30, 0);
        do_cmd("R7 isrc after reset", 0, 29, 0);
        do_cmd("R7 isrc cleared", 0, 29, 0);

        // R6 R10: full read sweep plus large numbers
        for (int r = 0; r <= 40; r++) do_cmd("R6 R10 read sweep", 0, r, 16'hFFFF);
        do_cmd("R10 read 100", 0, 100, 0);
        do_cmd("R10 read 511", 0, 511, 0);

        // R4 R5 R8: pattern sweeps on writable registers
        foreach (pat_q[i]) begin
            do_cmd("R4 control write", 1, 0, pat_q[i] & 16'h7FFF);
            do_cmd("R4 control read", 0, 0, 0);
            do_cmd("R4 status read", 0, 1, 0);
            do_cmd("R5 advert write", 1, 4, pat_q[i]);
            do_cmd("R5 advert read", 0, 4, 0);
            do_cmd("R8 mask write", 1, 30, pat_q[i]);
            do_cmd("R8 mask read", 0, 30, 0);
        end

        // R2 R7: link toggles with clear-on-read
        set_link(0);
        do_cmd("R2 status down", 0, 1, 0);
        do_cmd("R7 isrc down", 0, 29, 0);
        do_cmd("R4 aneg bit with link down", 1, 0, 16'h1000);
        do_cmd("R4 status bit5", 0, 1, 0);
        set_link(1);
        set_link(0);
        set_link(1);
        do_cmd("R2 status up", 0, 1, 0);
        do_cmd("R2 R7 isrc accumulated", 0, 29, 0);
        do_cmd("R7 isrc cleared again", 0, 29, 0);

        // R10 R6: writes to unlisted and constant numbers change nothing
        for (int r = 1; r <= 40; r++)
            if (r != 4 && r != 30 && r != 29) do_cmd("R10 write sweep", 1, r, 16'hFFFF);
        do_cmd("R10 write 511", 1, 511, 16'hFFFF);
        for (int r = 0; r <= 6; r++) do_cmd("R10 regs unchanged", 0, r, 0);
        do_cmd("R10 mask unchanged", 0, 30, 0);

        // R3: soft reset with link down and up
        set_link(0);
        do_cmd("R3 soft reset down", 1, 0, 16'h8000);
        for (int r = 0; r <= 6; r++) do_cmd("R3 after reset down", 0, r, 0);
        do_cmd("R3 isrc down", 0, 29, 0);
        do_cmd("R3 mask", 0, 30, 0);
        set_link(1);
        do_cmd("R3 soft reset up", 1, 0, 16'hFFFF);
        do_cmd("R3 status up", 0, 1, 0);
        do_cmd("R3 isrc up", 0, 29, 0);
        do_cmd("R3 control", 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    logic [15:0] pat_q [6] = '{16'h0000, 16'hFFFF, 16'hAAAA, 16'h5555, 16'h1000, 16'h0980};
endmodule